// File: doc/BRIEF.md
# Second-Operand Shifter with Constant Encoder

This block forms the second operand of a data-processing operation, together with the shifter carry that a flag-setting logical operation would take. It has two operand modes. In the constant mode, an 8-bit value is rotated right by twice a 4-bit rotate field. In the register mode, a 32-bit register value is shifted left, shifted right logically, shifted right arithmetically, rotated right, or rotated right through the carry by one place. The shift amount comes either from a 5-bit field in the operation word or from the low byte of a second register. The register file is not part of the block. The caller supplies the operand register value, the low byte of the amount register and the current carry flag along with the 12-bit operand field.

An operation is presented with `in_vld`. Constant operands and fixed-amount shifts are registered and appear one cycle later. A register-amount shift models the extra register read that it needs. The block holds its inputs for one cycle, raises `stall` during that cycle, and delivers the result one cycle after that. A separate combinational helper reports whether an arbitrary 32-bit constant can be written in the rotated-byte form. When it can, the helper gives the byte and the smallest rotate field that reproduces the constant.

Top module: `op2_shifter`

## Requirements
- R1: With `imm_mode`=1 the result is `op2_field[7:0]` zero-extended to 32 bits and rotated right by 2×`op2_field[11:8]` places (0, 2, … 30); for example byte 0xF2 with rotate 0xC gives 0x0000F200, byte 0x11 with rotate 8 gives 0x00110000, and byte 0x4A with rotate 0xB gives 0x00012800.
- R2: In constant mode, a rotate field of zero passes `c_in` to `carry_out`; any other rotate field makes `carry_out` equal bit 31 of the result.
- R3: With `imm_mode`=0 and `op2_field[4]`=0, the amount is `op2_field[11:7]` and the kind is `op2_field[6:5]` (00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right). For amounts 1 to 31: a left shift fills zeros and the carry is the last bit shifted out at the top. A logical right shift fills zeros and an arithmetic right shift fills copies of bit 31; for both, the carry is the last bit shifted out at the bottom. A rotate feeds the low bits back in at the top, and the carry is result bit 31.
- R4: In fixed-amount mode, an amount of 0 is special. A left shift by 0 passes the register and `c_in` unchanged. A logical right shift by 0 means a shift by 32 (result 0, carry = old bit 31). An arithmetic right shift by 0 means a shift by 32 (all sign bits, carry = old bit 31). A rotate by 0 means rotate right by one through the carry (result = {`c_in`, value[31:1]}, carry = value bit 0).
- R5: With `imm_mode`=0 and `op2_field[4]`=1, the amount is `rs_amt` (8 bits) and the kind is `op2_field[6:5]`. An amount of 0 passes the register and `c_in` unchanged for every kind. Amounts 1 to 31 behave as in R3.
- R6: Register amounts of 32 or more follow these rules. A left shift by 32 gives 0 with carry = bit 0, and a logical right shift by 32 gives 0 with carry = bit 31. Left and logical right shifts by more than 32 give 0 with carry 0. An arithmetic right shift by 32 or more gives all sign bits with carry = bit 31. A rotate uses the amount modulo 32; a non-zero amount whose modulo is zero returns the value unchanged with carry = bit 31.
- R7: A constant or fixed-amount operation accepted at a clock edge raises `out_vld` for the following cycle. A register-amount operation raises `stall` for the following cycle and `out_vld` for the cycle after that. `out_vld` is a one-cycle pulse, and `op2_out`/`carry_out` hold their last value between results.
- R8: `in_vld` is ignored in a cycle where `stall` is high: no result and no further stall come from it.
- R9: `enc_ok` is 1 exactly when `const_in` equals some byte rotated right by an even amount. The helper then returns in `enc_imm8`/`enc_rot` the byte and the smallest rotate field that reproduce it. Examples: 0xFF, 0x104, 0xFF0 and 0xFF00 are encodable, and 0x101, 0x102 and 0xFF1 are not.
- R10: While `rst_n` is low, `out_vld`, `stall`, `op2_out` and `carry_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation presented this cycle |
| imm_mode | input | 1 | 1: rotated constant, 0: register operand |
| op2_field | input | 12 | Operand-2 field of the operation word |
| rm_val | input | 32 | Value of the operand register |
| rs_amt | input | 8 | Low byte of the shift-amount register |
| c_in | input | 1 | Current carry flag |
| const_in | input | 32 | Constant to test for encodability |
| stall | output | 1 | Register-amount operation in its extra cycle |
| out_vld | output | 1 | Result valid pulse |
| op2_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |
| enc_ok | output | 1 | `const_in` is encodable |
| enc_imm8 | output | 8 | Byte of the encoding |
| enc_rot | output | 4 | Rotate field of the encoding |

## Verification
Constant and fixed-amount results are due one clock edge after the edge that accepts them. Register-amount results are due two edges later, with `stall` set in between. The encoder outputs are combinational and are due as soon as `const_in` settles. The bench runs its model on the same rising edge as the design and compares `stall`, `out_vld` and, when a result is due, the operand and carry at the following falling edge, so every comparison is made half a cycle after the registers move. Encoder results are checked one time unit after the constant is applied.

// File: rtl/op2_pkg.sv
package op2_pkg;
  localparam int OP2_DW    = 32;
  localparam int OP2_LW    = $clog2(OP2_DW);
  localparam int OP2_AMT_W = 8;
  localparam int OP2_IMM_W = 8;
  localparam int OP2_ROT_W = 4;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic [OP2_DW-1:0] value;
    logic              carry;
  } op2_res_t;

  // Rotate right by n places, n below the word width.
  function automatic logic [OP2_DW-1:0] rot_right(input logic [OP2_DW-1:0] v,
                                                  input logic [OP2_LW-1:0] n);
    logic [2*OP2_DW-1:0] d;
    d = {v, v} >> n;
    return d[OP2_DW-1:0];
  endfunction
endpackage

// File: rtl/op2_imm_rot.sv
module op2_imm_rot
  import op2_pkg::*;
#(
  parameter int W     = OP2_DW,
  parameter int IMM_W = OP2_IMM_W,
  parameter int ROT_W = OP2_ROT_W
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             cin,
  output op2_res_t         res
);
  localparam int LW = $clog2(W);
  logic [W-1:0]  widened;
  logic [LW-1:0] places;

  assign widened = {{(W-IMM_W){1'b0}}, imm};
  assign places  = {rot, 1'b0};

  always_comb begin
    res.value = rot_right(widened, places);
    res.carry = (rot == '0) ? cin : res.value[W-1];
  end
endmodule

// File: rtl/op2_shift_unit.sv
module op2_shift_unit
  import op2_pkg::*;
#(
  parameter int W     = OP2_DW,
  parameter int AMT_W = OP2_AMT_W
) (
  input  shift_kind_e      kind,
  input  logic             thru_carry,
  input  logic [AMT_W-1:0] amt,
  input  logic [W-1:0]     val,
  input  logic             cin,
  output op2_res_t         res
);
  localparam int LW = $clog2(W);

  logic [LW-1:0]  sa;
  logic           amt_zero;
  logic           amt_full;
  logic           amt_over;
  logic [W:0]     lsl_t;
  logic [W:0]     lsr_t;
  logic [W:0]     asr_t;
  logic [W-1:0]   ror_v;

  assign sa       = amt[LW-1:0];
  assign amt_zero = (amt == '0);
  assign amt_full = (amt == AMT_W'(W));
  assign amt_over = (amt > AMT_W'(W));

  assign lsl_t = {1'b0, val} << sa;
  assign lsr_t = {val, 1'b0} >> sa;
  assign asr_t = $signed({val, 1'b0}) >>> sa;
  assign ror_v = rot_right(val, sa);

  always_comb begin
    res.value = val;
    res.carry = cin;
    if (thru_carry) begin
      res.value = {cin, val[W-1:1]};
      res.carry = val[0];
    end else if (!amt_zero) begin
      unique case (kind)
        SK_LSL: begin
          if (amt_full) begin
            res.value = '0;
            res.carry = val[0];
          end else if (amt_over) begin
            res.value = '0;
            res.carry = 1'b0;
          end else begin
            res.value = lsl_t[W-1:0];
            res.carry = lsl_t[W];
          end
        end
        SK_LSR: begin
          if (amt_full) begin
            res.value = '0;
            res.carry = val[W-1];
          end else if (amt_over) begin
            res.value = '0;
            res.carry = 1'b0;
          end else begin
            res.value = lsr_t[W:1];
            res.carry = lsr_t[0];
          end
        end
        SK_ASR: begin
          if (amt_full || amt_over) begin
            res.value = {W{val[W-1]}};
            res.carry = val[W-1];
          end else begin
            res.value = asr_t[W:1];
            res.carry = asr_t[0];
          end
        end
        default: begin
          res.value = ror_v;
          res.carry = ror_v[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/op2_const_enc.sv
module op2_const_enc
  import op2_pkg::*;
#(
  parameter int W     = OP2_DW,
  parameter int IMM_W = OP2_IMM_W,
  parameter int ROT_W = OP2_ROT_W
) (
  input  logic [W-1:0]     value,
  output logic             ok,
  output logic [IMM_W-1:0] imm,
  output logic [ROT_W-1:0] rot
);
  localparam int LW     = $clog2(W);
  localparam int N_ROTS = 1 << ROT_W;

  logic [N_ROTS-1:0] fits;
  logic [IMM_W-1:0]  cand [N_ROTS];

  // Undo a right rotate of 2r by rotating right by W-2r.
  for (genvar r = 0; r < N_ROTS; r++) begin : g_cand
    localparam int UNDO = (W - 2*r) % W;
    logic [W-1:0] back;
    assign back    = rot_right(value, LW'(UNDO));
    assign fits[r] = (back[W-1:IMM_W] == '0);
    assign cand[r] = back[IMM_W-1:0];
  end

  // Lowest rotate field wins.
  always_comb begin
    ok  = 1'b0;
    imm = '0;
    rot = '0;
    for (int r = N_ROTS-1; r >= 0; r--) begin
      if (fits[r]) begin
        ok  = 1'b1;
        imm = cand[r];
        rot = ROT_W'(r);
      end
    end
  end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import op2_pkg::*;
#(
  parameter int W     = OP2_DW,
  parameter int AMT_W = OP2_AMT_W,
  parameter int IMM_W = OP2_IMM_W,
  parameter int ROT_W = OP2_ROT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             imm_mode,
  input  logic [11:0]      op2_field,
  input  logic [W-1:0]     rm_val,
  input  logic [AMT_W-1:0] rs_amt,
  input  logic             c_in,
  input  logic [W-1:0]     const_in,
  output logic             stall,
  output logic             out_vld,
  output logic [W-1:0]     op2_out,
  output logic             carry_out,
  output logic             enc_ok,
  output logic [IMM_W-1:0] enc_imm8,
  output logic [ROT_W-1:0] enc_rot
);
  localparam int SH5_W = 5;

  // Field decode; bit positions are fixed by the operation word.
  logic [ROT_W-1:0] f_rot;
  logic [IMM_W-1:0] f_imm;
  logic [SH5_W-1:0] f_sh5;
  shift_kind_e      f_kind;
  logic             f_by_reg;

  assign f_rot    = op2_field[11:8];
  assign f_imm    = op2_field[7:0];
  assign f_sh5    = op2_field[11:7];
  assign f_kind   = shift_kind_e'(op2_field[6:5]);
  assign f_by_reg = op2_field[4];

  // Named events, also used by the checker.
  logic stall_q;
  logic accept;
  logic take_now;
  logic launch_reg;
  logic finish_reg;

  assign accept     = in_vld && !stall_q;
  assign take_now   = accept && (imm_mode || !f_by_reg);
  assign launch_reg = accept && !imm_mode && f_by_reg;
  assign finish_reg = stall_q;

  // Fixed-amount remapping of the zero amount.
  logic [AMT_W-1:0] fix_amt;
  logic             fix_rrx;

  always_comb begin
    fix_amt = AMT_W'(f_sh5);
    fix_rrx = 1'b0;
    if (f_sh5 == '0) begin
      unique case (f_kind)
        SK_LSR, SK_ASR: fix_amt = AMT_W'(W);
        SK_ROR:         fix_rrx = 1'b1;
        default:        fix_amt = '0;
      endcase
    end
  end

  // Operands held across the extra read cycle.
  logic [W-1:0]     hold_val;
  logic [AMT_W-1:0] hold_amt;
  shift_kind_e      hold_kind;
  logic             hold_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_val  <= '0;
      hold_amt  <= '0;
      hold_kind <= SK_LSL;
      hold_c    <= 1'b0;
    end else if (launch_reg) begin
      hold_val  <= rm_val;
      hold_amt  <= rs_amt;
      hold_kind <= f_kind;
      hold_c    <= c_in;
    end
  end

  // One shifter serves both register forms.
  shift_kind_e      su_kind;
  logic             su_rrx;
  logic [AMT_W-1:0] su_amt;
  logic [W-1:0]     su_val;
  logic             su_cin;
  op2_res_t         su_res;
  op2_res_t         ir_res;
  op2_res_t         pick;

  assign su_kind = finish_reg ? hold_kind : f_kind;
  assign su_rrx  = finish_reg ? 1'b0      : fix_rrx;
  assign su_amt  = finish_reg ? hold_amt  : fix_amt;
  assign su_val  = finish_reg ? hold_val  : rm_val;
  assign su_cin  = finish_reg ? hold_c    : c_in;

  op2_shift_unit #(.W(W), .AMT_W(AMT_W)) u_shift (
    .kind       (su_kind),
    .thru_carry (su_rrx),
    .amt        (su_amt),
    .val        (su_val),
    .cin        (su_cin),
    .res        (su_res)
  );

  op2_imm_rot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm (f_imm),
    .rot (f_rot),
    .cin (c_in),
    .res (ir_res)
  );

  assign pick = (!finish_reg && imm_mode) ? ir_res : su_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q   <= 1'b0;
      out_vld   <= 1'b0;
      op2_out   <= '0;
      carry_out <= 1'b0;
    end else begin
      stall_q <= launch_reg;
      out_vld <= take_now || finish_reg;
      if (take_now || finish_reg) begin
        op2_out   <= pick.value;
        carry_out <= pick.carry;
      end
    end
  end

  assign stall = stall_q;

  op2_const_enc #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_enc (
    .value (const_in),
    .ok    (enc_ok),
    .imm   (enc_imm8),
    .rot   (enc_rot)
  );
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk
  import op2_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic        imm_mode,
  input logic [11:0] op2_field,
  input logic [31:0] rm_val,
  input logic        c_in,
  input logic [31:0] const_in,
  input logic        stall,
  input logic        out_vld,
  input logic [31:0] op2_out,
  input logic        carry_out,
  input logic        enc_ok,
  input logic [7:0]  enc_imm8,
  input logic [3:0]  enc_rot,
  input logic        take_now,
  input logic        launch_reg
);
  AST_IMM_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> (out_vld && !stall)); // R7

  AST_REG_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    launch_reg |=> (stall && !out_vld)); // R7

  AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (out_vld && !stall)); // R7

  AST_BUSY_DROPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && in_vld) |=> !stall); // R8

  AST_CONST_FEW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (take_now && imm_mode) |=> ($countones(op2_out) <= 8)); // R1

  AST_CONST_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_now && imm_mode && op2_field[11:8] == 4'h0) |=>
      (op2_out == {24'h0, $past(op2_field[7:0])} && carry_out == $past(c_in))); // R2

  AST_LSL_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_now && !imm_mode && op2_field[11:4] == 8'h00) |=>
      (op2_out == $past(rm_val) && carry_out == $past(c_in))); // R4

  AST_ENC_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    enc_ok |-> (rot_right({24'h0, enc_imm8}, {enc_rot, 1'b0}) == const_in)); // R9
endmodule

bind op2_shifter op2_shifter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .imm_mode   (imm_mode),
  .op2_field  (op2_field),
  .rm_val     (rm_val),
  .c_in       (c_in),
  .const_in   (const_in),
  .stall      (stall),
  .out_vld    (out_vld),
  .op2_out    (op2_out),
  .carry_out  (carry_out),
  .enc_ok     (enc_ok),
  .enc_imm8   (enc_imm8),
  .enc_rot    (enc_rot),
  .take_now   (take_now),
  .launch_reg (launch_reg)
);

// File: tb/op2_shifter_test.sv
`timescale 1ns/1ps
module op2_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        imm_mode = 1'b0;
  logic [11:0] op2_field = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_amt = '0;
  logic        c_in = 1'b0;
  logic [31:0] const_in = '0;
  logic        stall, out_vld, carry_out, enc_ok;
  logic [31:0] op2_out;
  logic [7:0]  enc_imm8;
  logic [3:0]  enc_rot;

  int total = 0;
  int bad = 0;
  bit done = 0;

  op2_shifter uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .imm_mode(imm_mode),
    .op2_field(op2_field), .rm_val(rm_val), .rs_amt(rs_amt), .c_in(c_in),
    .const_in(const_in), .stall(stall), .out_vld(out_vld), .op2_out(op2_out),
    .carry_out(carry_out), .enc_ok(enc_ok), .enc_imm8(enc_imm8), .enc_rot(enc_rot)
  );

  always #4 clk = ~clk;

  // ---------------- reference behaviour ----------------
  function automatic logic [31:0] ref_ror(logic [31:0] v, int n);
    logic [31:0] r = v;
    for (int i = 0; i < n % 32; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  // kind 0..3 as encoded, 4 = rotate through carry
  function automatic void ref_shift(int kind, logic [31:0] v, int amt, bit cin,
                                    output logic [31:0] r, output bit c);
    logic [63:0] t;
    logic signed [63:0] ts;
    r = v; c = cin;
    if (kind == 4) begin
      r = {cin, v[31:1]}; c = v[0];
    end else if (amt != 0) begin
      case (kind)
        0: begin t = {32'h0, v} << amt; r = t[31:0]; c = t[32]; end
        1: begin t = {v, 32'h0} >> amt; r = t[63:32]; c = t[31]; end
        2: begin ts = $signed({v, 32'h0}) >>> amt; r = ts[63:32]; c = ts[31]; end
        default: begin r = ref_ror(v, amt); c = r[31]; end
      endcase
    end
  endfunction

  function automatic bit ref_enc(logic [31:0] v, output int rot_o, output logic [7:0] imm_o);
    logic [31:0] back;
    for (int r = 0; r < 16; r++) begin
      back = ref_ror(v, 32 - 2*r);
      if (back < 256) begin
        rot_o = r; imm_o = back[7:0];
        return 1'b1;
      end
    end
    rot_o = 0; imm_o = 0;
    return 1'b0;
  endfunction

  // ---------------- cycle model ----------------
  bit          m_vld, m_stall, m_ign;
  logic [31:0] m_op;
  bit          m_c;
  string       m_tag = "R3";
  string       m_ctag = "R3";
  logic [31:0] h_val;
  int          h_amt, h_kind;
  bit          h_c;

  always @(posedge clk) begin : model
    bit nv;
    int kind, n;
    nv = 0;
    if (!rst_n) begin
      m_vld = 0; m_stall = 0; m_op = 0; m_c = 0; m_ign = 0;
    end else begin
      m_ign = 0;
      if (m_stall) begin
        m_ign = in_vld;
        ref_shift(h_kind, h_val, h_amt, h_c, m_op, m_c);
        m_tag = (h_amt >= 32) ? "R6" : "R5";
        m_ctag = m_tag;
        nv = 1; m_stall = 0;
      end else if (in_vld) begin
        if (imm_mode) begin
          m_op = ref_ror({24'h0, op2_field[7:0]}, 2 * int'(op2_field[11:8]));
          m_c = (op2_field[11:8] == 0) ? c_in : m_op[31];
          m_tag = "R1"; m_ctag = "R2"; nv = 1;
        end else if (!op2_field[4]) begin
          kind = int'(op2_field[6:5]);
          n = int'(op2_field[11:7]);
          if (n == 0 && kind == 3) kind = 4;
          else if (n == 0 && (kind == 1 || kind == 2)) n = 32;
          ref_shift(kind, rm_val, n, c_in, m_op, m_c);
          m_tag = (op2_field[11:7] == 0) ? "R4" : "R3";
          m_ctag = m_tag; nv = 1;
        end else begin
          h_val = rm_val; h_amt = int'(rs_amt); h_kind = int'(op2_field[6:5]);
          h_c = c_in; m_stall = 1;
        end
      end
      m_vld = nv;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_ign ? "R8" : "R7", "out_vld", 32'(out_vld), 32'(m_vld));
      chk(m_ign ? "R8" : "R7", "stall", 32'(stall), 32'(m_stall));
      if (m_vld) begin
        chk(m_ign ? "R8" : m_tag, "op2_out", op2_out, m_op);
        chk(m_ign ? "R8" : m_ctag, "carry_out", 32'(carry_out), 32'(m_c));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(bit im, logic [11:0] f, logic [31:0] rm, logic [7:0] rs, bit c);
    @(negedge clk);
    in_vld = 1; imm_mode = im; op2_field = f; rm_val = rm; rs_amt = rs; c_in = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 0;
    end
  endtask

  task automatic enc_check(logic [31:0] v, bit exp_ok, int exp_rot, logic [7:0] exp_imm);
    const_in = v;
    #1;
    chk("R9", "enc_ok", 32'(enc_ok), 32'(exp_ok));
    if (exp_ok) begin
      chk("R9", "enc_rot", 32'(enc_rot), 32'(exp_rot));
      chk("R9", "enc_imm8", 32'(enc_imm8), 32'(exp_imm));
    end
  endtask

  function automatic logic [11:0] f_fix(int n, int kind);
    return {n[4:0], kind[1:0], 1'b0, 4'h0};
  endfunction

  function automatic logic [11:0] f_reg(int kind);
    return {4'h3, 1'b0, kind[1:0], 1'b1, 4'h2};
  endfunction

  initial begin
    logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    int amts [10] = '{0, 1, 4, 31, 32, 33, 63, 64, 65, 255};
    int fix_n [4] = '{0, 1, 17, 31};
    @(negedge clk);
    // R10: reset state
    chk("R10", "out_vld", 32'(out_vld), 0);
    chk("R10", "stall", 32'(stall), 0);
    chk("R10", "op2_out", op2_out, 0);
    chk("R10", "carry_out", 32'(carry_out), 0);
    rst_n = 1;

    // R1, R2: constants
    drive(1, 12'hCF2, 0, 0, 0); idle(1);
    chk("R1", "F2 rot C", op2_out, 32'h0000_F200);
    drive(1, 12'h811, 0, 0, 1); idle(1);
    chk("R1", "11 rot 8", op2_out, 32'h0011_0000);
    drive(1, 12'hB4A, 0, 0, 0); idle(1);
    chk("R1", "4A rot B", op2_out, 32'h0001_2800);
    drive(1, 12'h0FF, 0, 0, 1); idle(1);
    chk("R2", "rot 0 keeps carry", 32'(carry_out), 1);
    drive(1, 12'h4FF, 0, 0, 0); idle(1);
    chk("R2", "rot 4 carry bit31", 32'(carry_out), 1);
    drive(1, 12'h180, 0, 0, 1);
    drive(1, 12'h201, 0, 0, 0);
    drive(1, 12'hF41, 0, 0, 1); idle(2);

    // R3, R4: fixed amounts
    foreach (pats[p])
      for (int k = 0; k < 4; k++)
        foreach (fix_n[i]) begin
          drive(0, f_fix(fix_n[i], k), pats[p], 8'hFF, 1'(p)); idle(1);
          drive(0, f_fix(fix_n[i], k), pats[p], 8'h00, 1'(p + 1));
        end
    idle(2);

    // R5, R6: register amounts
    foreach (pats[p])
      for (int k = 0; k < 4; k++)
        foreach (amts[i]) begin
          drive(0, f_reg(k), pats[p], 8'(amts[i]), 1'(i)); idle(3);
        end

    // R8: new request while the extra cycle is running
    drive(0, f_reg(1), 32'hF000_000F, 8'd4, 0);
    drive(1, 12'h0AA, 0, 0, 1);
    drive(0, f_reg(2), 32'h1234_5678, 8'd8, 1);
    idle(3);

    // R9: encoder
    enc_check(32'h0000_00FF, 1, 0, 8'hFF);
    enc_check(32'h0000_0104, 1, 15, 8'h41);
    enc_check(32'h0000_0FF0, 1, 14, 8'hFF);
    enc_check(32'h0000_FF00, 1, 12, 8'hFF);
    enc_check(32'h0000_F200, 1, 12, 8'hF2);
    enc_check(32'h0001_2800, 1, 11, 8'h4A);
    enc_check(32'h0000_0101, 0, 0, 0);
    enc_check(32'h0000_0102, 0, 0, 0);
    enc_check(32'h0000_0FF1, 0, 0, 0);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] v;
      int er;
      logic [7:0] ei;
      bit eo;
      v = (i % 2 == 0) ? ref_ror({24'h0, 8'($urandom)}, 2 * ($urandom % 16)) : $urandom;
      eo = ref_enc(v, er, ei);
      enc_check(v, eo, er, ei);
    end

    // mixed random traffic, all requirements
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      in_vld = ($urandom % 4) != 0;
      imm_mode = ($urandom % 3) == 0;
      op2_field = 12'($urandom);
      rm_val = $urandom;
      rs_amt = ($urandom % 2) ? 8'($urandom % 40) : 8'($urandom);
      c_in = 1'($urandom);
    end
    idle(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule